// File: doc/BRIEF.md
# Sync-Triggered Snapshot Capture

This block records a one-shot window of a streaming sample flow into on-chip memory so that a host can inspect it later. The host first prepares the capture: it holds the arm enable high and pulses the start control. The block then waits for the next sync pulse, counts a programmable number of clocks, and writes one sample per clock into its buffer until the buffer is full. After that it stops and raises a done flag.

Two sample formats are supported. In narrow real mode, the low byte of the real input is taken each clock, and four consecutive bytes are packed into each 32-bit word. In complex mode, the 16-bit real and imaginary parts are each zero-extended to 32 bits and written to two separate memories at the same address. A write-address status output shows how far the capture has progressed. A registered read port lets the host fetch words from either memory once the capture has finished.

Top module: `snap_capture`

## Requirements
- R1: After reset, `done` is 0, `wr_addr` is 0 and nothing is written until the block is armed.
- R2: A `start` pulse while `arm_en` is 0 is ignored: later sync pulses start no capture, and `done` and `wr_addr` stay 0.
- R3: A clock with `start` and `arm_en` both high arms the block. From the next clock, `done` is 0 and `wr_addr` is 0, and the block holds the `mode_cplx` and `delay` values sampled at that clock.
- R4: The cycle in which `sync_in` is first high after arming is cycle 0. The first captured sample is the one presented in cycle `delay`+1. A delay of 0 captures the sample in the cycle right after sync.
- R5: Sync pulses that arrive while the delay is counting, or during capture, neither restart nor shift the capture.
- R6: Narrow real mode (`mode_cplx`=0) packs `din_re[7:0]` of four consecutive samples into one real-memory word. The earliest sample goes in bits 7:0 and the latest in bits 31:24. The imaginary word at that address is 0.
- R7: Complex mode (`mode_cplx`=1) writes one word per sample. The real word is {16'h0, `din_re`} and the imaginary word is {16'h0, `din_im`}.
- R8: Capture is one-shot. After the word at address DEPTH-1 is written, `done` is 1 and `wr_addr` stays at DEPTH-1. No further sample or sync changes the memories until the block is re-armed.
- R9: During capture, `wr_addr` equals the number of words written since arming, capped at DEPTH-1.
- R10: `rd_re` and `rd_im` show the words at `rd_addr` one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_en | input | 1 | Host write-enable level that qualifies `start` |
| start | input | 1 | Host control pulse that arms a capture |
| mode_cplx | input | 1 | 0 = narrow real packing, 1 = complex zero-padded |
| delay | input | DLY_W | Clocks between sync and capture start |
| sync_in | input | 1 | Stream sync pulse |
| din_re | input | DIN_W | Real sample (low byte used in real mode) |
| din_im | input | DIN_W | Imaginary sample |
| rd_addr | input | AW | Host read address |
| rd_re | output | 32 | Real memory word, one clock after `rd_addr` |
| rd_im | output | 32 | Imaginary memory word, one clock after `rd_addr` |
| wr_addr | output | AW | Capture write-position status |
| done | output | 1 | Capture complete |

## Verification
The assertions assume that `start` is not pulsed while a capture is running. An arm in the middle of a capture is legal, but it resets the pointer and the packer, and the pointer-hold check expects no such reset. The bench arms only when the block is idle or done. It places every extra sync either inside the delay count, during capture or after completion. It reads the memories only after `done` is set, so the read port never overlaps a write to the same word.

// File: rtl/snap_pkg.sv
package snap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_DELAY = 2'd2,
        ST_RUN   = 2'd3
    } trig_state_e;

    typedef enum logic {
        MODE_REAL8  = 1'b0,
        MODE_CPLX16 = 1'b1
    } snap_mode_e;
endpackage

// File: rtl/snap_trigger.sv
module snap_trigger
    import snap_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_en,
    input  logic             start,
    input  logic             sync_in,
    input  logic             mode_cplx,
    input  logic [DLY_W-1:0] delay,
    input  logic             last_write,
    output logic             restart,
    output logic             cap_on,
    output logic             done,
    output snap_mode_e       mode
);
    typedef struct packed {
        trig_state_e      st;
        logic [DLY_W-1:0] cnt;
        logic [DLY_W-1:0] dly;
        snap_mode_e       mode;
        logic             done;
    } trig_regs_t;

    trig_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        restart = arm_en && start;
        if (restart) begin
            r_d.st   = ST_WAIT;
            r_d.done = 1'b0;
            r_d.dly  = delay;
            r_d.mode = snap_mode_e'(mode_cplx);
            r_d.cnt  = '0;
        end else begin
            case (r_q.st)
                ST_WAIT: begin
                    if (sync_in) begin
                        if (r_q.dly == '0) begin
                            r_d.st = ST_RUN;
                        end else begin
                            r_d.st  = ST_DELAY;
                            r_d.cnt = r_q.dly;
                        end
                    end
                end
                ST_DELAY: begin
                    if (r_q.cnt == DLY_W'(1)) r_d.st = ST_RUN;
                    else                      r_d.cnt = r_q.cnt - 1'b1;
                end
                ST_RUN: begin
                    if (last_write) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cap_on = (r_q.st == ST_RUN);
    assign done   = r_q.done;
    assign mode   = r_q.mode;

    // Sync during the count must not reload it
    assert_delay_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DELAY && r_q.cnt != DLY_W'(1) && !restart)
        |=> (r_q.st == ST_DELAY && r_q.cnt == $past(r_q.cnt) - 1'b1));

    // Sync while waiting always leaves the wait state
    assert_sync_leaves_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT && sync_in && !restart) |=> (r_q.st != ST_WAIT));
endmodule

// File: rtl/snap_packer.sv
module snap_packer
    import snap_pkg::*;
#(
    parameter int DIN_W  = 16,
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              cap_on,
    input  snap_mode_e        mode,
    input  logic [DIN_W-1:0]  din_re,
    input  logic [DIN_W-1:0]  din_im,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_re,
    output logic [WORD_W-1:0] wr_im
);
    localparam int LANES  = WORD_W / BYTE_W;
    localparam int LANE_W = $clog2(LANES);
    localparam int SR_W   = WORD_W - BYTE_W;

    typedef struct packed {
        logic [LANE_W-1:0] lane;
        logic [SR_W-1:0]   sr;
    } pack_regs_t;

    pack_regs_t p_d, p_q;

    always_comb begin
        p_d   = p_q;
        wr_en = 1'b0;
        wr_re = '0;
        wr_im = '0;
        if (restart) begin
            p_d = '0;
        end else if (cap_on) begin
            if (mode == MODE_CPLX16) begin
                wr_en = 1'b1;
                wr_re = WORD_W'(din_re);
                wr_im = WORD_W'(din_im);
            end else if (p_q.lane == LANE_W'(LANES - 1)) begin
                wr_en    = 1'b1;
                wr_re    = {din_re[BYTE_W-1:0], p_q.sr};
                p_d.lane = '0;
            end else begin
                p_d.sr[int'(p_q.lane)*BYTE_W +: BYTE_W] = din_re[BYTE_W-1:0];
                p_d.lane = p_q.lane + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    // A packed word is emitted only after the lane counter wraps
    assert_lane_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_on && !restart && mode == MODE_REAL8 && wr_en) |=> (p_q.lane == '0));
endmodule

// File: rtl/snap_buffer.sv
module snap_buffer #(
    parameter int DEPTH  = 4096,
    parameter int WORD_W = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_re,
    input  logic [WORD_W-1:0] wr_im,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_re,
    output logic [WORD_W-1:0] rd_im,
    output logic [AW-1:0]     ptr,
    output logic              last_write
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WORD_W-1:0] mem_re [DEPTH];
    logic [WORD_W-1:0] mem_im [DEPTH];
    logic [AW-1:0]     ptr_d, ptr_q;
    logic [WORD_W-1:0] rd_re_q, rd_im_q;

    always_comb begin
        ptr_d      = ptr_q;
        last_write = wr_en && (ptr_q == LAST);
        if (restart)                     ptr_d = '0;
        else if (wr_en && ptr_q != LAST) ptr_d = ptr_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_re[ptr_q] <= wr_re;
            mem_im[ptr_q] <= wr_im;
        end
        rd_re_q <= mem_re[rd_addr];
        rd_im_q <= mem_im[rd_addr];
    end

    assign ptr   = ptr_q;
    assign rd_re = rd_re_q;
    assign rd_im = rd_im_q;

    // Each accepted write below the top moves the pointer by one
    assert_ptr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !restart && ptr_q != LAST) |=> (ptr_q == $past(ptr_q) + 1'b1));
endmodule

// File: rtl/snap_capture.sv
module snap_capture
    import snap_pkg::*;
#(
    parameter int  DEPTH  = 4096,
    parameter int  DIN_W  = 16,
    parameter int  DLY_W  = 16,
    localparam int WORD_W = 32,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_en,
    input  logic              start,
    input  logic              mode_cplx,
    input  logic [DLY_W-1:0]  delay,
    input  logic              sync_in,
    input  logic [DIN_W-1:0]  din_re,
    input  logic [DIN_W-1:0]  din_im,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_re,
    output logic [WORD_W-1:0] rd_im,
    output logic [AW-1:0]     wr_addr,
    output logic              done
);
    logic              restart, cap_on, last_write, wr_en;
    snap_mode_e        mode;
    logic [WORD_W-1:0] wr_re, wr_im;

    snap_trigger #(.DLY_W(DLY_W)) u_trig (
        .clk(clk), .rst_n(rst_n), .arm_en(arm_en), .start(start),
        .sync_in(sync_in), .mode_cplx(mode_cplx), .delay(delay),
        .last_write(last_write), .restart(restart), .cap_on(cap_on),
        .done(done), .mode(mode)
    );

    snap_packer #(.DIN_W(DIN_W), .WORD_W(WORD_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .restart(restart), .cap_on(cap_on),
        .mode(mode), .din_re(din_re), .din_im(din_im),
        .wr_en(wr_en), .wr_re(wr_re), .wr_im(wr_im)
    );

    snap_buffer #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .restart(restart), .wr_en(wr_en),
        .wr_re(wr_re), .wr_im(wr_im), .rd_addr(rd_addr),
        .rd_re(rd_re), .rd_im(rd_im), .ptr(wr_addr), .last_write(last_write)
    );

    assert_write_only_in_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> cap_on);

    assert_done_holds_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !restart) |=> (done && $stable(wr_addr)));

    assert_arm_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (wr_addr == '0 && !done));
endmodule

// File: tb/snap_capture_test.sv
module snap_capture_test;
    localparam int CLK_P = 10;
    localparam int DEPTH = 8;
    localparam int AW    = $clog2(DEPTH);

    typedef struct packed {
        logic        cplx;
        logic [7:0]  dly;
        logic [15:0] seed;
        logic        resync;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b1, 8'd0, 16'h1234, 1'b0},
        '{1'b0, 8'd0, 16'h00A5, 1'b0},
        '{1'b1, 8'd3, 16'hBEEF, 1'b1},
        '{1'b0, 8'd2, 16'h0F0F, 1'b1},
        '{1'b1, 8'd1, 16'h7001, 1'b0},
        '{1'b0, 8'd5, 16'h3C3C, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic arm_en = 1'b0, start = 1'b0, mode_cplx = 1'b0, sync_in = 1'b0;
    logic [7:0]  delay = '0;
    logic [15:0] din_re = '0, din_im = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0] rd_re, rd_im;
    logic [AW-1:0] wr_addr;
    logic done;
    int total = 0, bad = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    snap_capture #(.DEPTH(DEPTH), .DIN_W(16), .DLY_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .arm_en(arm_en), .start(start),
        .mode_cplx(mode_cplx), .delay(delay), .sync_in(sync_in),
        .din_re(din_re), .din_im(din_im), .rd_addr(rd_addr),
        .rd_re(rd_re), .rd_im(rd_im), .wr_addr(wr_addr), .done(done)
    );

    function automatic logic [15:0] re_of(logic [15:0] seed, int k);
        return 16'(seed + 16'(k) * 16'd37);
    endfunction

    function automatic logic [15:0] im_of(logic [15:0] seed, int k);
        return 16'(~seed + 16'(k) * 16'd11);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int spw, k0, kmax, s, words, exp_ptr;
        logic [31:0] exp_re, exp_im;
        spw  = v.cplx ? 1 : 4;
        k0   = int'(v.dly) + 1;
        kmax = k0 + DEPTH * spw + 4;
        // arm
        arm_en = 1'b1; start = 1'b1; mode_cplx = v.cplx; delay = v.dly; sync_in = 1'b0;
        @(negedge clk);
        start = 1'b0; arm_en = 1'b0;
        delay = 8'hFF; mode_cplx = ~v.cplx;
        chk(done == 1'b0, "R3", "done after arm", 32'(done), 0);
        chk(wr_addr == '0, "R3", "wr_addr after arm", 32'(wr_addr), 0);
        for (int k = 0; k < kmax; k++) begin
            s       = (k > k0) ? k - k0 : 0;
            words   = s / spw;
            exp_ptr = (words > DEPTH - 1) ? DEPTH - 1 : words;
            chk(wr_addr == AW'(exp_ptr), "R9", "wr_addr progress", 32'(wr_addr), 32'(exp_ptr));
            chk(done == (words >= DEPTH), "R8", "done flag", 32'(done), 32'(words >= DEPTH));
            sync_in = (k == 0) || (v.resync && (k == 2 || k == kmax - 2));
            din_re  = re_of(v.seed, k);
            din_im  = im_of(v.seed, k);
            @(negedge clk);
        end
        sync_in = 1'b0;
        for (int w = 0; w < DEPTH; w++) begin
            rd_addr = AW'(w);
            @(negedge clk);
            if (v.cplx) begin
                exp_re = {16'h0, re_of(v.seed, k0 + w)};
                exp_im = {16'h0, im_of(v.seed, k0 + w)};
                chk(rd_re == exp_re, "R7 R4 R5 R10", "complex real word", rd_re, exp_re);
                chk(rd_im == exp_im, "R7 R10", "complex imag word", rd_im, exp_im);
            end else begin
                for (int j = 0; j < 4; j++)
                    exp_re[j*8 +: 8] = re_of(v.seed, k0 + 4*w + j)[7:0];
                chk(rd_re == exp_re, "R6 R4 R5 R10", "packed real word", rd_re, exp_re);
                chk(rd_im == 32'h0, "R6", "imag word in real mode", rd_im, 0);
            end
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R1", "done after reset", 32'(done), 0);
        chk(wr_addr == '0, "R1", "wr_addr after reset", 32'(wr_addr), 0);
        // start without arm enable, then syncs and data
        start = 1'b1; mode_cplx = 1'b1; delay = 8'd0;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 20; k++) begin
            sync_in = (k % 5 == 0);
            din_re  = 16'(k); din_im = 16'(k);
            @(negedge clk);
        end
        sync_in = 1'b0;
        chk(done == 1'b0, "R2", "done without arm", 32'(done), 0);
        chk(wr_addr == '0, "R2", "wr_addr without arm", 32'(wr_addr), 0);
        for (int i = 0; i < 6; i++) run_vec(VECS[i]);
        // after completion, extra syncs and samples leave state unchanged
        for (int k = 0; k < 12; k++) begin
            sync_in = (k % 3 == 0);
            din_re  = 16'hFFFF; din_im = 16'hFFFF;
            @(negedge clk);
        end
        sync_in = 1'b0;
        chk(done == 1'b1, "R8", "done holds", 32'(done), 1);
        chk(wr_addr == AW'(DEPTH - 1), "R8", "wr_addr holds", 32'(wr_addr), 32'(DEPTH - 1));
        rd_addr = '0;
        @(negedge clk);
        chk(rd_im == 32'h0, "R8", "word 0 untouched", rd_im, 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule